// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits behind the host's single data window into a network controller's packet memory. Every host read or write on that window moves one, two or four bytes at the current remote pointer. The pointer then advances by the number of bytes moved, wrapping from the receive ring's stop page back to its start page. A remaining-byte counter counts down, and the block raises a one-cycle completion pulse when the counter runs out.

Accesses reach one of two regions. The first is a small station-address store at the bottom of the address space, which is loaded from a 48-bit station address on reset. The second is a packet-memory window held outside the block and reached through a byte-addressed, 32-bit-lane memory port. Any address outside both regions reads as all ones and takes no writes. The pointer and the counter are loaded through dedicated load strobes, and both are visible as outputs. Register decoding belongs to a neighbouring block.

Top module: `rdma_port_engine`

## Requirements
- R1: For an access with `portSize[1]` clear (byte or word request), `cfgWide`=1 moves 2 bytes and `cfgWide`=0 moves 1 byte. For an access with `portSize[1]` set (long request), 4 bytes move whatever `cfgWide` holds.
- R2: After an accepted access, `curAddr` grows by the number of bytes moved. If the result equals `stopPage` shifted left by 8, `startPage` shifted left by 8 is loaded in its place.
- R3: If `curCount` is at or below the bytes moved, it becomes 0 and `dmaDone` is high for exactly the next cycle. Otherwise `curCount` drops by the bytes moved.
- R4: A write while `curCount` is 0 has no effect. Memory, the station store, `curAddr` and `curCount` keep their values, and `dmaDone` stays low.
- R5: A read while `curCount` is 0 still returns data and advances `curAddr`. `curCount` stays at 0 and `dmaDone` pulses.
- R6: A 2- or 4-byte access uses the pointer with bit 0 cleared. Byte n of the access sits on data bits [8n+7:8n], least significant byte first. Read lanes beyond the length moved are 0.
- R7: An access address below 32 selects the station store. An access address at or above 2048 whose last byte lies below 4096 selects packet memory. Any other access reads all ones over its length and writes nothing.
- R8: Reset fills station-store bytes 2i and 2i+1 with entry i of a 16-entry list. Entries 0-5 are the station address bytes (byte 0 is `stationAddr[7:0]`), entries 14 and 15 are 0x57, and the other entries are 0.
- R9: Port writes into the station store change it, and later reads return the written bytes.
- R10: `addrLoad` and `cntLoad` set `curAddr` and `curCount` in the next cycle. They take precedence over an access in the same cycle, and a cycle with `cntLoad` raises no `dmaDone`.
- R11: After reset `curAddr` and `curCount` are 0 and `dmaDone` is low.
- R12: Accesses in consecutive cycles each use the pointer left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portRd | input | 1 | Host read on the data window |
| portWr | input | 1 | Host write on the data window (wins over portRd) |
| portSize | input | 2 | Access size request; bit 1 set means long |
| portWdata | input | 32 | Host write data, little-endian lanes |
| portRdata | output | 32 | Host read data for the current access |
| cfgWide | input | 1 | Data-width configuration bit for byte/word requests |
| startPage | input | 8 | Ring start page |
| stopPage | input | 8 | Ring stop page (one past the end) |
| addrLoad | input | 1 | Load the remote pointer |
| addrIn | input | 16 | Pointer load value |
| cntLoad | input | 1 | Load the remaining-byte counter |
| cntIn | input | 16 | Counter load value |
| stationAddr | input | 48 | Station address used to fill the store on reset |
| memAddr | output | 16 | Packet-memory byte address of lane 0 |
| memWe | output | 1 | Packet-memory write enable |
| memBe | output | 4 | Packet-memory lane enables |
| memWdata | output | 32 | Packet-memory write data |
| memRdata | input | 32 | Packet-memory read data, combinational |
| curAddr | output | 16 | Live remote pointer |
| curCount | output | 16 | Live remaining-byte counter |
| dmaDone | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is an exhausted counter meeting different access kinds. The stimulus drives the count to zero through a word access whose length exceeds the single byte left. It then issues a dropped write, followed by reads at odd pointers that must realign and keep pulsing completion. A byte left in place by the dropped write is read back later through the port. The same approach covers ring wrap under a long access and long reads straddling the top of memory. For each, a load strobe places the pointer a few bytes from the edge, so the exact boundary cycle is hit without walking the whole ring.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  // Lane-enable patterns for the three transfer lengths.
  localparam logic [3:0] LANES_ONE  = 4'h1;
  localparam logic [3:0] LANES_TWO  = 4'h3;
  localparam logic [3:0] LANES_FOUR = 4'hF;

  // Strobes from the control to the datapath for the current access.
  typedef struct packed {
    logic       romWr;     // commit write lanes into the station store
    logic       memWr;     // commit write lanes into packet memory
    logic       romSel;    // access address hits the station store
    logic       memSel;    // access address hits the packet window
    logic [3:0] laneMask;  // lanes taking part in the access
  } dp_strobe_t;

endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int PAGE_SHIFT = 8,
  parameter int MEM_SIZE   = 4096,
  parameter int PMEM_START = 2048,
  parameter int ROM_BYTES  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 portRd,
  input  logic                 portWr,
  input  logic [1:0]           portSize,
  input  logic                 cfgWide,
  input  logic [AW-PAGE_SHIFT-1:0] startPage,
  input  logic [AW-PAGE_SHIFT-1:0] stopPage,
  input  logic                 addrLoad,
  input  logic [AW-1:0]        addrIn,
  input  logic                 cntLoad,
  input  logic [CW-1:0]        cntIn,
  output logic [AW-1:0]        accAddr,
  output dp_strobe_t           strobe,
  output logic [AW-1:0]        addrQ,
  output logic [CW-1:0]        cntQ,
  output logic                 doneQ
);

  localparam logic [AW:0] MEM_END  = (AW+1)'(MEM_SIZE);
  localparam logic [AW-1:0] PM_LOW = AW'(PMEM_START);
  localparam logic [AW-1:0] ROM_TOP = AW'(ROM_BYTES);

  logic [2:0]    accLen;
  logic          multiByte;
  logic [AW:0]   endAddr;
  logic          romHit, memHit;
  logic          cntZero, wrFire, rdFire, fire;
  logic [AW-1:0] startAddr, stopAddr, addrSum, addrNext;
  logic          cntLast;

  // Transfer length: long requests always move four bytes.
  always_comb begin
    if (portSize[1])  accLen = 3'd4;
    else if (cfgWide) accLen = 3'd2;
    else              accLen = 3'd1;
  end

  assign multiByte = (accLen != 3'd1);
  assign accAddr   = multiByte ? {addrQ[AW-1:1], 1'b0} : addrQ;
  assign endAddr   = {1'b0, accAddr} + (AW+1)'(accLen);

  assign romHit = (accAddr < ROM_TOP);
  assign memHit = (accAddr >= PM_LOW) && (endAddr <= MEM_END);

  assign cntZero = (cntQ == '0);
  assign wrFire  = portWr && !cntZero;
  assign rdFire  = portRd && !portWr;
  assign fire    = wrFire || rdFire;

  always_comb begin
    strobe.romWr  = wrFire && romHit;
    strobe.memWr  = wrFire && memHit;
    strobe.romSel = romHit;
    strobe.memSel = memHit;
    case (accLen)
      3'd4:    strobe.laneMask = LANES_FOUR;
      3'd2:    strobe.laneMask = LANES_TWO;
      default: strobe.laneMask = LANES_ONE;
    endcase
  end

  assign startAddr = {startPage, {PAGE_SHIFT{1'b0}}};
  assign stopAddr  = {stopPage,  {PAGE_SHIFT{1'b0}}};
  assign addrSum   = addrQ + AW'(accLen);
  assign addrNext  = (addrSum == stopAddr) ? startAddr : addrSum;
  assign cntLast   = (cntQ <= CW'(accLen));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (addrLoad)  addrQ <= addrIn;
      else if (fire) addrQ <= addrNext;
      if (cntLoad) begin
        cntQ <= cntIn;
      end else if (fire) begin
        if (cntLast) begin
          cntQ  <= '0;
          doneQ <= 1'b1;
        end else begin
          cntQ <= cntQ - CW'(accLen);
        end
      end
    end
  end

  AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && cntZero && !addrLoad && !cntLoad) |=> ($stable(addrQ) && $stable(cntQ) && !doneQ)); // R4
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (cntQ == '0)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdFire && !cntLoad && (cntQ > CW'(4))) |=>
      ((($past(cntQ) - cntQ) == CW'(1)) || (($past(cntQ) - cntQ) == CW'(2)) ||
       (($past(cntQ) - cntQ) == CW'(4)))); // R1

endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PMEM_START = 2048,
  parameter int ROM_BYTES  = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_strobe_t    strobe,
  input  logic [AW-1:0] accAddr,
  input  logic [47:0]   stationAddr,
  input  logic [31:0]   portWdata,
  input  logic [31:0]   memRdata,
  output logic [31:0]   portRdata,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic [3:0]    memBe,
  output logic [31:0]   memWdata
);

  localparam int RW    = $clog2(ROM_BYTES);
  localparam int LANES = 4;

  logic [7:0]    romQ [ROM_BYTES];
  logic [RW-1:0] laneIdx [LANES];

  // Reset content: entry i of the 16-entry list lands at bytes 2i and 2i+1.
  function automatic logic [7:0] romInit(input int idx, input logic [47:0] sta);
    int entry;
    entry = idx / 2;
    if (entry < 6)                       return sta[entry*8 +: 8];
    else if (entry == 14 || entry == 15) return 8'h57;
    else                                 return 8'h00;
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneIdx[k] = accAddr[RW-1:0] + RW'(k);
    assign portRdata[8*k +: 8] =
      !strobe.laneMask[k] ? 8'h00 :
      strobe.romSel       ? romQ[laneIdx[k]] :
      strobe.memSel       ? memRdata[8*k +: 8] : 8'hFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROM_BYTES; i++) romQ[i] <= romInit(i, stationAddr);
    end else if (strobe.romWr) begin
      for (int k = 0; k < LANES; k++)
        if (strobe.laneMask[k]) romQ[laneIdx[k]] <= portWdata[8*k +: 8];
    end
  end

  assign memAddr  = accAddr;
  assign memWe    = strobe.memWr;
  assign memBe    = strobe.laneMask;
  assign memWdata = portWdata;

  AST_MEM_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr >= AW'(PMEM_START))); // R7
  AST_NO_DUAL_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.romWr && strobe.memWr)); // R7

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int PAGE_SHIFT = 8,
  parameter int MEM_SIZE   = 4096,
  parameter int PMEM_START = 2048,
  parameter int ROM_BYTES  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        portRd,
  input  logic        portWr,
  input  logic [1:0]  portSize,
  input  logic [31:0] portWdata,
  output logic [31:0] portRdata,
  input  logic        cfgWide,
  input  logic [AW-PAGE_SHIFT-1:0] startPage,
  input  logic [AW-PAGE_SHIFT-1:0] stopPage,
  input  logic        addrLoad,
  input  logic [AW-1:0] addrIn,
  input  logic        cntLoad,
  input  logic [CW-1:0] cntIn,
  input  logic [47:0] stationAddr,
  output logic [AW-1:0] memAddr,
  output logic        memWe,
  output logic [3:0]  memBe,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic [AW-1:0] curAddr,
  output logic [CW-1:0] curCount,
  output logic        dmaDone
);

  dp_strobe_t    strobe;
  logic [AW-1:0] accAddr;

  rdma_ctrl #(
    .AW(AW), .CW(CW), .PAGE_SHIFT(PAGE_SHIFT), .MEM_SIZE(MEM_SIZE),
    .PMEM_START(PMEM_START), .ROM_BYTES(ROM_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .portRd(portRd), .portWr(portWr),
    .portSize(portSize), .cfgWide(cfgWide), .startPage(startPage),
    .stopPage(stopPage), .addrLoad(addrLoad), .addrIn(addrIn),
    .cntLoad(cntLoad), .cntIn(cntIn), .accAddr(accAddr), .strobe(strobe),
    .addrQ(curAddr), .cntQ(curCount), .doneQ(dmaDone)
  );

  rdma_datapath #(
    .AW(AW), .PMEM_START(PMEM_START), .ROM_BYTES(ROM_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accAddr(accAddr),
    .stationAddr(stationAddr), .portWdata(portWdata), .memRdata(memRdata),
    .portRdata(portRdata), .memAddr(memAddr), .memWe(memWe), .memBe(memBe),
    .memWdata(memWdata)
  );

  AST_WE_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (portWr && (curCount != '0))); // R4
  AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ((memBe == 4'h1) || (memBe == 4'h3) || (memBe == 4'hF))); // R1

endmodule

// File: tb/rdma_port_engine_tb.sv
`timescale 1ns/1ps
module rdma_port_engine_tb;

  localparam int MEM_SIZE   = 4096;
  localparam int PMEM_START = 2048;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_LD = 2'd2;
  localparam logic [1:0] SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  size;
    logic        wide;
    logic [31:0] data;   // write data, or {count, address} for a load
    logic [15:0] eAddr;
    logic [15:0] eCnt;
    logic        eDone;
    logic [31:0] eRd;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{OP_LD, SZ_B, 1'b0, 32'h000A0800, 16'h0800, 16'h000A, 1'b0, 32'h0},
    '{OP_WR, SZ_B, 1'b0, 32'h00000011, 16'h0801, 16'h0009, 1'b0, 32'h0},       // R1 byte
    '{OP_WR, SZ_B, 1'b0, 32'h00000022, 16'h0802, 16'h0008, 1'b0, 32'h0},
    '{OP_WR, SZ_W, 1'b1, 32'h00004433, 16'h0804, 16'h0006, 1'b0, 32'h0},       // R1 word
    '{OP_WR, SZ_L, 1'b0, 32'h88776655, 16'h0808, 16'h0002, 1'b0, 32'h0},       // R1 long
    '{OP_WR, SZ_W, 1'b0, 32'h00000099, 16'h0809, 16'h0001, 1'b0, 32'h0},       // R1 word req, narrow
    '{OP_WR, SZ_W, 1'b1, 32'h0000BBAA, 16'h080B, 16'h0000, 1'b1, 32'h0},       // R3 R6 odd pointer
    '{OP_WR, SZ_B, 1'b0, 32'h000000CC, 16'h080B, 16'h0000, 1'b0, 32'h0},       // R4 dropped
    '{OP_LD, SZ_B, 1'b0, 32'h00040800, 16'h0800, 16'h0004, 1'b0, 32'h0},
    '{OP_RD, SZ_L, 1'b0, 32'h0,        16'h0804, 16'h0000, 1'b1, 32'h44332211}, // R6
    '{OP_RD, SZ_W, 1'b1, 32'h0,        16'h0806, 16'h0000, 1'b1, 32'h00006655}, // R5
    '{OP_RD, SZ_B, 1'b0, 32'h0,        16'h0807, 16'h0000, 1'b1, 32'h00000077}, // R5
    '{OP_RD, SZ_B, 1'b1, 32'h0,        16'h0809, 16'h0000, 1'b1, 32'h00008877}, // R1 R6
    '{OP_RD, SZ_W, 1'b1, 32'h0,        16'h080B, 16'h0000, 1'b1, 32'h0000BBAA}, // R6
    '{OP_RD, SZ_B, 1'b0, 32'h0,        16'h080C, 16'h0000, 1'b1, 32'h0000000B}, // R4 untouched
    '{OP_LD, SZ_B, 1'b0, 32'h010009FE, 16'h09FE, 16'h0100, 1'b0, 32'h0},
    '{OP_RD, SZ_W, 1'b1, 32'h0,        16'h0800, 16'h00FE, 1'b0, 32'h0000FFFE}, // R2 wrap
    '{OP_RD, SZ_B, 1'b0, 32'h0,        16'h0801, 16'h00FD, 1'b0, 32'h00000011},
    '{OP_LD, SZ_B, 1'b0, 32'h002009FC, 16'h09FC, 16'h0020, 1'b0, 32'h0},
    '{OP_WR, SZ_L, 1'b0, 32'hDDCCBBAA, 16'h0800, 16'h001C, 1'b0, 32'h0},       // R2 wrap on long
    '{OP_LD, SZ_B, 1'b0, 32'h000409FC, 16'h09FC, 16'h0004, 1'b0, 32'h0},
    '{OP_RD, SZ_L, 1'b0, 32'h0,        16'h0800, 16'h0000, 1'b1, 32'hDDCCBBAA},
    '{OP_LD, SZ_B, 1'b0, 32'h00100000, 16'h0000, 16'h0010, 1'b0, 32'h0},
    '{OP_RD, SZ_L, 1'b0, 32'h0,        16'h0004, 16'h000C, 1'b0, 32'hA2A2A1A1}, // R8
    '{OP_LD, SZ_B, 1'b0, 32'h0010001C, 16'h001C, 16'h0010, 1'b0, 32'h0},
    '{OP_RD, SZ_L, 1'b0, 32'h0,        16'h0020, 16'h000C, 1'b0, 32'h57575757}, // R8
    '{OP_LD, SZ_B, 1'b0, 32'h00020010, 16'h0010, 16'h0002, 1'b0, 32'h0},
    '{OP_WR, SZ_W, 1'b1, 32'h0000BEEF, 16'h0012, 16'h0000, 1'b1, 32'h0},       // R9
    '{OP_LD, SZ_B, 1'b0, 32'h00020010, 16'h0010, 16'h0002, 1'b0, 32'h0},
    '{OP_RD, SZ_W, 1'b1, 32'h0,        16'h0012, 16'h0000, 1'b1, 32'h0000BEEF}, // R9
    '{OP_LD, SZ_B, 1'b0, 32'h00080100, 16'h0100, 16'h0008, 1'b0, 32'h0},
    '{OP_RD, SZ_L, 1'b0, 32'h0,        16'h0104, 16'h0004, 1'b0, 32'hFFFFFFFF}, // R7 gap
    '{OP_WR, SZ_B, 1'b0, 32'h00000033, 16'h0105, 16'h0003, 1'b0, 32'h0},       // R7 dropped
    '{OP_RD, SZ_B, 1'b0, 32'h0,        16'h0106, 16'h0002, 1'b0, 32'h000000FF}, // R7
    '{OP_LD, SZ_B, 1'b0, 32'h01000FFC, 16'h0FFC, 16'h0100, 1'b0, 32'h0},
    '{OP_RD, SZ_W, 1'b1, 32'h0,        16'h0FFE, 16'h00FE, 1'b0, 32'h0000FDFC},
    '{OP_LD, SZ_B, 1'b0, 32'h01000FFC, 16'h0FFC, 16'h0100, 1'b0, 32'h0},
    '{OP_RD, SZ_L, 1'b0, 32'h0,        16'h1000, 16'h00FC, 1'b0, 32'hFFFEFDFC}, // R7 last fit
    '{OP_LD, SZ_B, 1'b0, 32'h01000FFE, 16'h0FFE, 16'h0100, 1'b0, 32'h0},
    '{OP_RD, SZ_L, 1'b0, 32'h0,        16'h1002, 16'h00FC, 1'b0, 32'hFFFFFFFF}  // R7 overhang
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portRd = 1'b0, portWr = 1'b0, cfgWide = 1'b0;
  logic [1:0]  portSize = 2'd0;
  logic [31:0] portWdata = '0;
  logic [31:0] portRdata;
  logic [7:0]  startPage = 8'h08, stopPage = 8'h0A;
  logic        addrLoad = 1'b0, cntLoad = 1'b0;
  logic [15:0] addrIn = '0, cntIn = '0;
  logic [47:0] stationAddr = 48'hA6A5A4A3A2A1;
  logic [15:0] memAddr;
  logic        memWe;
  logic [3:0]  memBe;
  logic [31:0] memWdata, memRdata;
  logic [15:0] curAddr, curCount;
  logic        dmaDone;

  int checks = 0;
  int errors = 0;
  int strayWrites = 0;
  logic [7:0] mem [MEM_SIZE];

  always #10 clk = ~clk;

  rdma_port_engine u_dut (
    .clk(clk), .rstN(rstN), .portRd(portRd), .portWr(portWr),
    .portSize(portSize), .portWdata(portWdata), .portRdata(portRdata),
    .cfgWide(cfgWide), .startPage(startPage), .stopPage(stopPage),
    .addrLoad(addrLoad), .addrIn(addrIn), .cntLoad(cntLoad), .cntIn(cntIn),
    .stationAddr(stationAddr), .memAddr(memAddr), .memWe(memWe),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .curAddr(curAddr), .curCount(curCount), .dmaDone(dmaDone)
  );

  // Packet memory model: filled with the low address byte while in reset.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_SIZE; i++) mem[i] <= 8'(i);
    end else if (memWe) begin
      if (int'(memAddr) < PMEM_START) strayWrites <= strayWrites + 1;
      for (int k = 0; k < 4; k++)
        if (memBe[k] && (int'(memAddr) + k < MEM_SIZE))
          mem[int'(memAddr) + k] <= memWdata[8*k +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++)
      memRdata[8*k +: 8] = (int'(memAddr) + k < MEM_SIZE) ? mem[int'(memAddr) + k] : 8'h00;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic runVec(input vec_t v, input int n);
    logic [31:0] rd;
    portRd    = (v.op == OP_RD);
    portWr    = (v.op == OP_WR);
    portSize  = v.size;
    cfgWide   = v.wide;
    portWdata = v.data;
    addrLoad  = (v.op == OP_LD);
    cntLoad   = (v.op == OP_LD);
    addrIn    = v.data[15:0];
    cntIn     = v.data[31:16];
    #1 rd = portRdata;
    @(posedge clk);
    #1;
    portRd = 1'b0; portWr = 1'b0; addrLoad = 1'b0; cntLoad = 1'b0;
    if (v.op == OP_RD) check("R6", $sformatf("vec %0d read data", n), rd, v.eRd);
    check("R2", $sformatf("vec %0d pointer", n), 32'(curAddr), 32'(v.eAddr));
    check("R3", $sformatf("vec %0d count", n), 32'(curCount), 32'(v.eCnt));
    check("R3", $sformatf("vec %0d done", n), 32'(dmaDone), 32'(v.eDone));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11 reset state
    check("R11", "reset pointer", 32'(curAddr), 32'h0);
    check("R11", "reset count", 32'(curCount), 32'h0);
    check("R11", "reset done", 32'(dmaDone), 32'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runVec(VEC[i], i);
      if (i == 32) check("R7", "stray memory writes", 32'(strayWrites), 32'h0);
    end

    // R10: loads win over a simultaneous read
    portRd = 1'b1; portSize = SZ_B; cfgWide = 1'b0;
    addrLoad = 1'b1; addrIn = 16'h0800; cntLoad = 1'b1; cntIn = 16'h0005;
    @(posedge clk);
    #1;
    addrLoad = 1'b0; cntLoad = 1'b0;
    check("R10", "load pointer priority", 32'(curAddr), 32'h0800);
    check("R10", "load count priority", 32'(curCount), 32'h0005);
    check("R10", "no done with load", 32'(dmaDone), 32'h0);
    portRd = 1'b0;
    @(negedge clk);

    // R12: three byte reads in consecutive cycles
    portRd = 1'b1;
    #1 check("R12", "first back-to-back byte", portRdata, 32'h11);
    @(negedge clk);
    #1 check("R12", "second back-to-back byte", portRdata, 32'h22);
    @(negedge clk);
    #1 check("R12", "third back-to-back byte", portRdata, 32'h33);
    @(posedge clk);
    #1 portRd = 1'b0;
    check("R12", "pointer after burst", 32'(curAddr), 32'h0803);
    check("R12", "count after burst", 32'(curCount), 32'h0002);
    @(negedge clk);

    // R8: a second reset restores the station store over the written bytes
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R11", "pointer after second reset", 32'(curAddr), 32'h0);
    check("R11", "count after second reset", 32'(curCount), 32'h0);
    @(negedge clk);
    runVec('{OP_LD, SZ_B, 1'b0, 32'h00020010, 16'h0010, 16'h0002, 1'b0, 32'h0}, 100);
    runVec('{OP_RD, SZ_W, 1'b1, 32'h0, 16'h0012, 16'h0000, 1'b1, 32'h00000000}, 101); // R8
    runVec('{OP_LD, SZ_B, 1'b0, 32'h00010000, 16'h0000, 16'h0001, 1'b0, 32'h0}, 102);
    runVec('{OP_RD, SZ_B, 1'b0, 32'h0, 16'h0001, 16'h0000, 1'b1, 32'h000000A1}, 103); // R8

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule